// File: doc/BRIEF.md
# Fractional-N Clock Enable Divider

This block derives a slow output rate from a fast master clock by division only; it never produces a rate above the master clock. Every output period lasts either N or N+1 master cycles. An unsigned phase accumulator picks between the two lengths, one period at a time, so the average division ratio is N plus a binary fraction. Any single output edge lands at most one master cycle away from its ideal position. For acceptable jitter, the master clock should run at least sixteen times faster than the synthesized rate.

Two outputs are produced. The first is a one-cycle pulse that marks the start of each output period and serves as a clock enable for downstream logic. The second is a square wave, high for the first half of each period. The divisor and the fractional step are plain control inputs. They are read only at a period boundary, so software or a controller may change them at any time without corrupting the period in flight. The block has no data stream and therefore no valid/ready handshake.

Top module: `fracn_clkdiv`

## Requirements
- R1: While the synchronous reset `srst` is held, `pulse_o` and `square_o` are both 0. After release, `square_o` stays 0 until the first pulse.
- R2: When `srst` is released, the first `pulse_o` appears on the N-th rising clock edge that has reset low. N is the clamped divisor present during reset.
- R3: `pulse_o` is high for exactly one master cycle, at the first cycle of each output period.
- R4: Each output period, measured from one pulse to the next, lasts N or N+1 master cycles. With `frac_step` equal to 0, every period lasts exactly N cycles.
- R5: At each period start, the 16-bit unsigned `frac_step` is added to a 16-bit accumulator. A carry out of bit 15 makes that period N+1 cycles long; otherwise the period is N cycles long.
- R6: With N and `frac_step` held constant, any 65536 consecutive output periods together last exactly 65536·N + `frac_step` master cycles.
- R7: `div_n` is an 8-bit unsigned value. Values 0 and 1 are treated as 2.
- R8: `div_n` and `frac_step` are sampled only at the edge that starts a period. A change during a period has no effect on the length of that period.
- R9: `square_o` is high for floor(L/2) master cycles from the start of each period of length L, and low for the rest of the period.
- R10: Reset clears the accumulator. The period sequence after a reset therefore depends only on the inputs applied after that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| srst | input | 1 | Synchronous reset, active high |
| div_n | input | 8 | Integer divisor N, clamped to a minimum of 2 |
| frac_step | input | 16 | Fractional increment added once per period |
| pulse_o | output | 1 | One-cycle marker at the start of each period |
| square_o | output | 1 | Roughly 50% duty output, high in the first half of each period |

## Verification
The bench targets the following corner cases:

- **Step of one half.** Periods must alternate N, N+1, N, … starting with N. A design that tested the carry before adding, or that accumulated into a register wider than 16 bits, would shift or lose the stretched periods.
- **Divisors 0 and 1.** These must produce periods of 2 or 3 cycles. Without the clamp, the counter would wrap to 256 or emit back-to-back pulses.
- **Largest divisor with an all-ones step.** This case exposes a counter one bit too narrow.
- **Odd and even periods.** The high time of the square output is checked in both. A threshold off by one would stretch or clip the high phase.
- **Inputs changed mid-period.** A design that sampled them continuously would cut the running period short.
- **Reset in the middle of a period.** The first-pulse delay must restart. A design that kept its accumulator would produce a different stretched-period pattern afterwards.
- **Long run.** Over 65536 periods, the exact total master-cycle count must match. An accumulator that dropped or duplicated a carry would show a nonzero drift.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Smallest divisor the period counter can run with: one pulse cycle
  // plus at least one idle cycle.
  localparam int unsigned MIN_DIV = 2;
  // Phase accumulator width fixed by the fractional step word.
  localparam int unsigned FRAC_W  = 16;
endpackage

// File: rtl/fd_phase_acc.sv
module fd_phase_acc #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          step,
  input  logic [FW-1:0] inc,
  output logic          carry
);
  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;

  // The carry out of this addition decides whether the period
  // starting now is stretched by one cycle.
  assign sum   = {1'b0, acc_q} + {1'b0, inc};
  assign carry = sum[FW];

  always_ff @(posedge clk) begin
    if (srst)      acc_q <= '0;
    else if (step) acc_q <= sum[FW-1:0];
  end

  // Between period starts the phase must not move.
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (srst)
    !step |=> $stable(acc_q)); // R8
endmodule

// File: rtl/fd_period_ctr.sv
module fd_period_ctr #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [LW-1:0] rst_len,
  input  logic [LW-1:0] load_len,
  output logic          start,
  output logic [LW-1:0] rem
);
  // rem holds the number of cycles left in the current period,
  // counting the present one; the last cycle launches the next period.
  assign start = (rem == LW'(1));

  always_ff @(posedge clk) begin
    if (srst)       rem <= rst_len;
    else if (start) rem <= load_len;
    else            rem <= rem - LW'(1);
  end

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (srst)
    rem != '0); // R4
  AST_REM_COUNTDOWN: assert property (@(posedge clk) disable iff (srst)
    !start |=> rem == $past(rem) - LW'(1)); // R4
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (srst)
    start |=> rem >= LW'(2)); // R7
endmodule

// File: rtl/fd_square.sv
module fd_square #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] rem,
  output logic          sq
);
  // thr_q = L - floor(L/2). While the remaining count after this cycle
  // stays above it, the period is still in its first half.
  logic [LW-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      thr_q <= '1;
      sq    <= 1'b0;
    end else if (start) begin
      thr_q <= len - (len >> 1);
      sq    <= 1'b1;
    end else begin
      sq    <= (rem - LW'(1)) > thr_q;
    end
  end

  AST_SQ_HIGH_AT_START: assert property (@(posedge clk) disable iff (srst)
    start |=> sq); // R9
endmodule

// File: rtl/fracn_clkdiv.sv
module fracn_clkdiv
  import fracn_pkg::*;
#(
  parameter int NW = 8,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          srst,
  input  logic [NW-1:0] div_n,
  input  logic [FW-1:0] frac_step,
  output logic          pulse_o,
  output logic          square_o
);
  localparam int LW = NW + 1;

  logic [NW-1:0] n_eff;
  logic          carry;
  logic          start;
  logic [LW-1:0] next_len;
  logic [LW-1:0] rem;

  assign n_eff    = (div_n < NW'(MIN_DIV)) ? NW'(MIN_DIV) : div_n;
  assign next_len = {1'b0, n_eff} + LW'(carry);

  fd_phase_acc #(.FW(FW)) u_acc (
    .clk   (clk),
    .srst  (srst),
    .step  (start),
    .inc   (frac_step),
    .carry (carry)
  );

  fd_period_ctr #(.LW(LW)) u_ctr (
    .clk      (clk),
    .srst     (srst),
    .rst_len  ({1'b0, n_eff}),
    .load_len (next_len),
    .start    (start),
    .rem      (rem)
  );

  fd_square #(.LW(LW)) u_sq (
    .clk   (clk),
    .srst  (srst),
    .start (start),
    .len   (next_len),
    .rem   (rem),
    .sq    (square_o)
  );

  always_ff @(posedge clk) begin
    if (srst) pulse_o <= 1'b0;
    else      pulse_o <= start;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (srst)
    pulse_o |=> !pulse_o); // R3
  AST_SQ_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (srst)
    $rose(square_o) |-> pulse_o); // R9
  AST_PULSE_FROM_COUNTER: assert property (@(posedge clk) disable iff (srst)
    start |=> pulse_o); // R3
endmodule

// File: tb/sim_fracn_clkdiv.sv
module sim_fracn_clkdiv;
  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [7:0]  div_n = 8'd10;
  logic [15:0] frac_step = 16'd0;
  logic        pulse_o;
  logic        square_o;

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  int unsigned expq[$];
  int unsigned exp_first = 10;
  int unsigned m_acc = 0;

  fracn_clkdiv #(.NW(8), .FW(16)) u0 (
    .clk(clk), .srst(srst), .div_n(div_n), .frac_step(frac_step),
    .pulse_o(pulse_o), .square_o(square_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned clampn(int unsigned n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_tick();
    do begin @(posedge clk); #2; end while (pulse_o !== 1'b1);
  endtask

  // Scoreboard driver: applies N and F, predicts the next `count`
  // period lengths from the accumulator rule, then waits for them.
  task automatic seg(input int unsigned n, input int unsigned f,
                     input int unsigned count);
    div_n = n[7:0];
    frac_step = f[15:0];
    for (int i = 0; i < count; i++) begin
      int unsigned s;
      s = m_acc + f;
      m_acc = s & 32'hFFFF;
      expq.push_back(clampn(n) + (s >> 16));
    end
    for (int i = 0; i < count; i++) wait_tick();
  endtask

  task automatic do_reset(input int unsigned n);
    @(posedge clk); #2;
    srst = 1'b1;
    div_n = n[7:0];
    repeat (3) @(posedge clk);
    #2;
    expq.delete();
    m_acc = 0;
    exp_first = clampn(n);
    srst = 1'b0;
  endtask

  // Monitor: measures periods and square high time, pops expectations.
  bit was_rst = 0, have_tick = 0, seen_first = 0, prev_pulse = 0;
  int unsigned since_rel = 0, per_cnt = 0, sq_hi = 0;

  always @(negedge clk) begin
    if (srst) begin
      if (was_rst)
        check(pulse_o === 1'b0 && square_o === 1'b0, "R1 outputs in reset",
              {pulse_o, square_o}, 0);
      was_rst = 1; have_tick = 0; seen_first = 0; prev_pulse = 0;
    end else begin
      if (was_rst) since_rel = 0; else since_rel++;
      was_rst = 0;
      if (!seen_first && pulse_o !== 1'b1)
        check(square_o === 1'b0, "R1 square before first pulse", square_o, 0);
      if (pulse_o === 1'b1) begin
        check(!prev_pulse, "R3 pulse width", 2, 1);
        if (!seen_first) begin
          check(since_rel == exp_first, "R2 first pulse delay", since_rel, exp_first);
          seen_first = 1;
        end else if (have_tick) begin
          if (expq.size() == 0) begin
            check(0, "R4 unexpected period", per_cnt, 0);
          end else begin
            int unsigned e;
            e = expq.pop_front();
            check(per_cnt == e, "R4 R5 R7 R8 R10 period length", per_cnt, e);
            check(sq_hi == e / 2, "R9 square high time", sq_hi, e / 2);
          end
        end
        have_tick = 1;
        per_cnt = 1;
        sq_hi = (square_o === 1'b1) ? 1 : 0;
      end else if (have_tick) begin
        per_cnt++;
        if (square_o === 1'b1) sq_hi++;
      end
      prev_pulse = (pulse_o === 1'b1);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 180000) begin
        errors++; checks++;
        $display("FAIL R6 watchdog actual=%0d expected=<=180000", cyc);
        report();
      end
    end
  end

  initial begin
    int unsigned t1, t2;
    do_reset(10);                 // R1 R2
    seg(10, 0, 5);                // R4 plain integer divide
    seg(7, 16'h8000, 8);          // R5 alternate 7,8
    seg(1, 16'h4000, 8);          // R7 clamp of 1
    seg(0, 0, 4);                 // R7 clamp of 0
    seg(255, 16'hFFFF, 3);        // R5 widest period
    seg(13, 16'h1000, 20);        // R9 odd and even lengths
    seg(6, 16'h2AAA, 6);          // R8 change mid-period
    do_reset(5);                  // R10 reset mid-period
    seg(5, 16'h5555, 10);         // R10 sequence from cleared phase
    // R6: exact long-run cycle total
    div_n = 8'd2;
    frac_step = 16'h1235;
    for (int i = 0; i < 65537; i++) begin
      int unsigned s;
      s = m_acc + 32'h1235;
      m_acc = s & 32'hFFFF;
      expq.push_back(2 + (s >> 16));
    end
    wait_tick();
    t1 = cyc;
    repeat (65536) wait_tick();
    t2 = cyc;
    check((t2 - t1) == 65536 * 2 + 32'h1235, "R6 long-run total",
          t2 - t1, 65536 * 2 + 32'h1235);
    wait_tick();
    @(negedge clk); #1;
    check(expq.size() == 0, "R4 all periods seen", expq.size(), 0);
    report();
  end
endmodule